// File: doc/BRIEF.md
# Quad potentiometer register file with staged non-volatile commit

This block keeps the register state of a four-channel digitally controlled potentiometer behind a serial front end. The front end hands it one byte-wide read or write request at a time and signals the end of each transaction. Every channel address carries two bytes: a volatile wiper setting that drives the channel's output lane, and a non-volatile initial value. The access byte at address 8 has a select bit that chooses which of the two a channel address reaches.

Writes to non-volatile bytes are held in a staging register. They are committed only after the transaction ends and a timed busy interval has run, which stands in for a real non-volatile programming cycle. Writes to volatile bytes take effect at once. A transaction that touched only volatile bytes never raises busy.

Top module: `potreg_file`

## Requirements
- R1: After reset, all four wiper lanes on `wiper_out` read 8'h80, `busy` is 0, and reads return 8'h80 at addresses 0 to 3 and 8'h00 at addresses 6 and 8.
- R2: With bit 7 of the access byte clear, a write to address n (0 to 3) sets wiper n. The new value shows in byte lane n of `wiper_out` (bits 8n+7:8n) one cycle after the request, and a read of address n returns it.
- R3: With bit 7 of the access byte set, addresses 0 to 3 reach the initial-value bytes. Writes to them leave `wiper_out` unchanged, and reads return the initial value.
- R4: Addresses 4, 5, 7 and 9 to 15 read as 8'h00, and writes to them change nothing that can be read back.
- R5: When a transaction ends with no non-volatile write staged, `busy` stays 0.
- R6: When a transaction ends with a non-volatile write staged, `busy` rises in the next cycle and stays high for exactly COMMIT_CYCLES cycles.
- R7: A staged non-volatile write is not visible to reads until its busy interval has completed. Afterwards, reads return the new value.
- R8: Requests issued while `busy` is high are ignored. No byte changes and `rd_data` holds its value.
- R9: Address 6 is a non-volatile general-purpose byte. If several non-volatile writes occur in one transaction, only the last one is committed.
- R10: Address 8 is a volatile access byte. Writes to it are readable at once and never start a busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| txn_end | input | 1 | One-cycle pulse marking the end of a transaction |
| rd_data | output | 8 | Read result, registered |
| busy | output | 1 | High during the emulated non-volatile commit |
| wiper_out | output | 32 | Four wiper bytes, channel n in bits 8n+7:8n |

## Verification
Read data and wiper lanes are due one clock edge after the request strobe. Busy rises one edge after the end pulse and falls COMMIT_CYCLES edges later, and the committed byte is readable from that same edge. The bench drives every input on the falling edge. It samples on the falling edge that follows the edge where a result is due, and it counts busy by falling edges, so each expected value is compared exactly where it is due. Both select modes are swept over all sixteen addresses, with an arithmetic model of every byte.

// File: rtl/potreg_file.sv
module potreg_file #(
  parameter int          COMMIT_CYCLES = 20,
  parameter logic [7:0]  IVR_PRESET    = 8'h80,
  parameter int          SEL_BIT       = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        txn_end,
  output logic [7:0]  rd_data,
  output logic        busy,
  output logic [31:0] wiper_out
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);

  logic [7:0]    wiper [4];
  logic [7:0]    ivr   [4];
  logic [7:0]    gp, acr, pend_data;
  logic [3:0]    pend_addr;
  logic          pend_valid;
  logic [CW-1:0] cnt;
  logic [7:0]    rd_next;

  wire go        = req_valid & ~busy;
  wire is_ch     = (req_addr[3:2] == 2'b00);
  wire nv_sel    = acr[SEL_BIT];
  wire nv_target = (is_ch & nv_sel) | (req_addr == 4'd6);
  wire start     = txn_end & pend_valid & ~busy;

  assign busy      = (cnt != '0);
  assign wiper_out = {wiper[3], wiper[2], wiper[1], wiper[0]};

  always_comb begin
    rd_next = 8'h00;
    if (is_ch)                  rd_next = nv_sel ? ivr[req_addr[1:0]] : wiper[req_addr[1:0]];
    else if (req_addr == 4'd6)  rd_next = gp;
    else if (req_addr == 4'd8)  rd_next = acr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        ivr[i]   <= IVR_PRESET;
        wiper[i] <= IVR_PRESET;
      end
      gp         <= 8'h00;
      acr        <= 8'h00;
      pend_data  <= 8'h00;
      pend_addr  <= 4'd0;
      pend_valid <= 1'b0;
      cnt        <= '0;
      rd_data    <= 8'h00;
    end else begin
      if (go && req_write) begin
        if (nv_target) begin
          pend_valid <= 1'b1;
          pend_addr  <= req_addr;
          pend_data  <= req_wdata;
        end else if (is_ch) begin
          wiper[req_addr[1:0]] <= req_wdata;
        end else if (req_addr == 4'd8) begin
          acr <= req_wdata;
        end
      end
      if (go && !req_write) rd_data <= rd_next;
      if (start) begin
        cnt <= CW'(COMMIT_CYCLES);
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          pend_valid <= 1'b0;
          if (pend_addr == 4'd6) gp <= pend_data;
          else                   ivr[pend_addr[1:0]] <= pend_data;
        end
      end
    end
  end

  AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CW'(1)) |=> busy); // R6
  AST_VOLATILE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !pend_valid && !busy) |=> !busy); // R5
  AST_WIPERS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wiper_out)); // R8
  AST_RDATA_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_data)); // R8
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !req_write && (req_addr == 4'd4 || req_addr == 4'd5 || req_addr == 4'd7 || req_addr > 4'd8))
    |=> rd_data == 8'h00); // R4
  AST_NO_STAGE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !pend_valid); // R7
endmodule

// File: tb/potreg_file_tb_top.sv
`timescale 1ns/1ps
module potreg_file_tb_top;
  localparam int C = 20;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, txn_end = 0;
  logic [3:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic [7:0] rd_data;
  logic busy;
  logic [31:0] wiper_out;

  int checks = 0, fails = 0;
  logic [7:0] mw [4];
  logic [7:0] mi [4];
  logic [7:0] mg, mac, mpd;
  logic [3:0] mpa;
  logic mpv;

  always #2.5 clk = ~clk;

  potreg_file #(.COMMIT_CYCLES(C)) dut_i (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a < 4)       return mac[7] ? mi[a[1:0]] : mw[a[1:0]];
    else if (a == 6) return mg;
    else if (a == 8) return mac;
    return 8'h00;
  endfunction

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d, input logic model);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    if (model) begin
      if ((a < 4 && mac[7]) || a == 6) begin mpv = 1; mpa = a; mpd = d; end
      else if (a < 4) mw[a[1:0]] = d;
      else if (a == 8) mac = d;
    end
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic end_txn();
    int n;
    @(negedge clk);
    txn_end = 1;
    @(negedge clk);
    txn_end = 0;
    if (mpv) begin
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(n == C, "R6 busy length", n, C);
      if (mpa == 6) mg = mpd; else mi[mpa[1:0]] = mpd;
      mpv = 0;
    end else begin
      chk(busy == 0, "R5/R10 no busy after volatile-only txn", busy, 0);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int a = 0; a < 16; a++) do_rd(a[3:0], exp_rd(a[3:0]), tag);
    chk(wiper_out == {mw[3], mw[2], mw[1], mw[0]}, "R2/R3 wiper lanes", wiper_out, {mw[3], mw[2], mw[1], mw[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mw[i] = 8'h80; mi[i] = 8'h80; end
    mg = 0; mac = 0; mpv = 0; mpa = 0; mpd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wiper_out == 32'h80808080, "R1 reset wipers", wiper_out, 32'h80808080);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk_all("R1 reset reads");

    do_wr(4'd2, 8'h3C, 1);
    chk(wiper_out[23:16] == 8'h3C, "R2 lane 2 one cycle after write", wiper_out[23:16], 8'h3C);
    end_txn();

    for (int m = 0; m < 2; m++) begin
      do_wr(4'd8, m ? 8'h80 : 8'h00, 1);
      do_rd(4'd8, mac, "R10 access byte readback");
      end_txn();
      for (int a = 0; a < 16; a++) begin
        if (a == 8) continue;
        do_wr(a[3:0], 8'(a * 37 + m * 91 + 5), 1);
        if (mpv) do_rd(a[3:0], exp_rd(a[3:0]), "R7 staged write hidden");
        end_txn();
        chk_all(m ? "R3/R4/R9 sweep nv" : "R2/R4 sweep volatile");
      end
    end

    do_wr(4'd6, 8'h11, 1);
    do_wr(4'd1, 8'h22, 1);
    do_wr(4'd6, 8'h5A, 1);
    end_txn();
    do_rd(4'd6, 8'h5A, "R9 last write wins gp");
    do_rd(4'd1, mi[1], "R9 earlier staged write dropped");
    chk(mi[1] != 8'h22, "R9 model sanity", mi[1], 8'h22);

    do_wr(4'd3, 8'hE7, 1);
    @(negedge clk); txn_end = 1; @(negedge clk); txn_end = 0;
    chk(busy == 1, "R6 busy rises next cycle", busy, 1);
    do_wr(4'd8, 8'h00, 0);
    do_wr(4'd6, 8'h99, 0);
    do_rd(4'd0, rd_data, "R8 rd_data holds while busy");
    while (busy) @(negedge clk);
    mi[3] = 8'hE7; mpv = 0;
    do_rd(4'd8, 8'h80, "R8 access write ignored while busy");
    do_rd(4'd6, 8'h5A, "R8 gp write ignored while busy");
    do_rd(4'd3, 8'hE7, "R7 committed after interval");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule